// File: doc/BRIEF.md
# Radix-16 Floating-Point Multiplier with Single-Precision Rounding

This block multiplies two 36-bit radix-16 floating-point operands. Its results match a single-precision binary multiply with round-to-nearest-even bit for bit, and this includes results that single precision would hold as subnormals. Each operand word has four fields. Bit 35 is the sign. Bit 34 marks a special value, and when it is set, bit 33 selects NaN (1) or infinity (0). Bits 33:27 hold a 7-bit exponent. Bits 26:0 hold a mantissa with an explicit leading one. A finite word has the value (-1)^s · mant · 2^(4·exp − 407), and zero is all-zero apart from the sign. A normalized mantissa has a one somewhere in bits 26:23.

The datapath has six pipeline registers:
1. Operand capture and classification.
2. Split partial products.
3. The full 54-bit product and the exponent sum.
4. A one-digit normalizer.
5. Rounding, where the position of the kept bits depends on both the leading nibble and the result exponent.
6. Carry fix-up and packing.

Callers present legal operands, meaning values that single precision can represent, together with `in_valid`. The product appears six clocks later with `out_valid`.

Top module: `hrfp_mul`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly six rising clock edges, and reset (`rst` high, synchronous) clears every stage so that `out_valid` is 0.
- R2: The sign of every non-NaN result (finite, zero or infinity) is the XOR of the operand signs.
- R3: When the result exponent is 65 or more, or is 64 with a one in mantissa bit 26 or 25, the result keeps 24 bits starting at the leading one. The bits below them are rounded to nearest-even and then cleared.
- R4: When the result exponent is 64 and mantissa bits 26:25 are zero, the ULP is mantissa bit 2. When the exponent is 63 down to 58, the ULP is bit 2+4·(64−exp), which is bit 26 at exponent 58. Rounding is to nearest-even at that ULP.
- R5: A result whose exponent would be 57 or less, or whose rounded mantissa is zero, is emitted as a signed zero: exponent and mantissa fields all zero.
- R6: A rounding carry out of mantissa bit 26 produces mantissa 0x0800000 and increments the exponent by one.
- R7: A finite result whose exponent after rounding exceeds 127 is emitted as infinity: bit 34 = 1, bits 33:0 = 0.
- R8: A NaN operand, or infinity times zero, yields the single NaN code: bit 35 = 0, bits 34:33 = 11, bits 32:0 = 0.
- R9: Infinity times a nonzero finite value or infinity gives a signed infinity. Zero times a finite value gives a signed zero.
- R10: In every finite result, the guard, round and sticky positions below the kept 24 bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 36 | First operand, radix-16 format |
| op_b | input | 36 | Second operand, radix-16 format |
| out_valid | output | 1 | `result` holds a product |
| result | output | 36 | Rounded product, radix-16 format |

## Verification
The bench targets the following cases:
- Ties at the smallest subnormal ULP. A design that rounds away from even there returns 2^-149 where zero is due.
- The largest subnormal times one-plus-an-ULP, which must become the smallest normal. An exponent-64 rule that picked the wrong rounding position would lose or keep a stray low bit.
- Products just below a power of sixteen. Their rounding carry must renormalize, so a missing fix-up shows up as a mantissa with bit 27 dropped or a stale exponent.
- Inf×0, NaN propagation and overflow to infinity.
- Thousands of random products whose exponent sums fall in the subnormal band. These exercise each of the seven ULP positions against an exact integer model.

// File: rtl/hrfp_pkg.sv
`timescale 1ns/1ps
package hrfp_pkg;
    // Word layout: [35] sign, [34] special, [33:27] exponent, [26:0] mantissa
    localparam int MANT_W   = 27;
    localparam int EXP_W    = 7;
    localparam int WORD_W   = 2 + EXP_W + MANT_W;
    localparam int DIGIT_W  = 4;
    localparam int PROD_W   = 2 * MANT_W;
    localparam int LO_W     = 13;
    localparam int HI_W     = MANT_W - LO_W;
    localparam int ESUM_W   = EXP_W + 1;
    localparam int EXPS_W   = ESUM_W + 2;
    localparam int KEEP_W   = 24;
    localparam int LEAD_LO  = KEEP_W - 1;          // lowest legal leading-one index
    localparam int BIAS_WIDE = 95;                  // bias when normalizer does not shift
    localparam int EXP_EDGE  = 64;                  // boundary of subnormal emulation
    localparam int EXP_FLUSH = 57;                  // at or below: zero
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int SUB_ULP   = 2;                   // ULP index at the boundary exponent
    localparam int RND_W     = MANT_W + 3;          // carry + mantissa + guard + sticky

    typedef logic [WORD_W-1:0]        word_t;
    typedef logic [MANT_W-1:0]        mant_t;
    typedef logic [EXP_W-1:0]         exp_t;
    typedef logic [ESUM_W-1:0]        esum_t;
    typedef logic signed [EXPS_W-1:0] sexp_t;
    typedef logic [PROD_W-1:0]        prod_t;

    typedef enum logic [1:0] {K_FIN, K_ZERO, K_INF, K_NAN} kind_t;

    typedef struct packed {
        logic  valid;
        logic  sign;
        kind_t kind;
        exp_t  ea;
        exp_t  eb;
        mant_t ma;
        mant_t mb;
    } cap_t;

    typedef struct packed {
        logic                   valid;
        logic                   sign;
        kind_t                  kind;
        esum_t                  esum;
        logic [MANT_W+LO_W-1:0] pp_lo;
        logic [MANT_W+HI_W-1:0] pp_hi;
    } part_t;

    typedef struct packed {
        logic  valid;
        logic  sign;
        kind_t kind;
        esum_t esum;
        prod_t prod;
    } full_t;

    typedef struct packed {
        logic  valid;
        logic  sign;
        kind_t kind;
        sexp_t e;
        mant_t m;
        logic  g0;
        logic  s0;
    } norm_t;

    typedef struct packed {
        logic              valid;
        logic              sign;
        kind_t             kind;
        sexp_t             e;
        logic              flush;
        logic [MANT_W:0]   mrnd;
    } rnd_t;

    function automatic logic is_nan(word_t w);
        return w[WORD_W-2] & w[WORD_W-3];
    endfunction

    function automatic logic is_inf(word_t w);
        return w[WORD_W-2] & ~w[WORD_W-3];
    endfunction

    function automatic logic is_zero(word_t w);
        return ~w[WORD_W-2] && (w[WORD_W-3:0] == '0);
    endfunction

    function automatic kind_t product_kind(word_t a, word_t b);
        if (is_nan(a) || is_nan(b) || (is_inf(a) && is_zero(b)) || (is_inf(b) && is_zero(a)))
            return K_NAN;
        if (is_inf(a) || is_inf(b))
            return K_INF;
        if (is_zero(a) || is_zero(b))
            return K_ZERO;
        return K_FIN;
    endfunction

    function automatic word_t special_word(kind_t k, logic s);
        case (k)
            K_NAN:   return {1'b0, 2'b11, {(WORD_W-3){1'b0}}};
            K_INF:   return {s, 2'b10, {(WORD_W-3){1'b0}}};
            default: return {s, {(WORD_W-1){1'b0}}};
        endcase
    endfunction
endpackage

// File: rtl/hrfp_mul_product.sv
`timescale 1ns/1ps
module hrfp_mul_product
    import hrfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cap_t  cap,
    output full_t full
);
    part_t part;
    part_t part_d;

    always_comb begin
        part_d.valid = cap.valid;
        part_d.sign  = cap.sign;
        part_d.kind  = cap.kind;
        part_d.esum  = esum_t'(cap.ea) + esum_t'(cap.eb);
        part_d.pp_lo = (MANT_W+LO_W)'(cap.ma) * (MANT_W+LO_W)'(cap.mb[LO_W-1:0]);
        part_d.pp_hi = (MANT_W+HI_W)'(cap.ma) * (MANT_W+HI_W)'(cap.mb[MANT_W-1:LO_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) part <= '0;
        else     part <= part_d;
    end

    full_t full_d;
    always_comb begin
        full_d.valid = part.valid;
        full_d.sign  = part.sign;
        full_d.kind  = part.kind;
        full_d.esum  = part.esum;
        full_d.prod  = PROD_W'(part.pp_lo) + {part.pp_hi, {LO_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) full <= '0;
        else     full <= full_d;
    end
endmodule

// File: rtl/hrfp_mul_normalize.sv
`timescale 1ns/1ps
module hrfp_mul_normalize
    import hrfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  full_t full,
    output norm_t norm
);
    localparam int TOP   = PROD_W - 1;
    localparam int G_W   = PROD_W - MANT_W - 1;      // guard index, wide window
    localparam int G_N   = G_W - DIGIT_W;            // guard index, shifted window

    logic  top_digit;
    norm_t norm_d;

    always_comb begin
        top_digit    = |full.prod[TOP -: DIGIT_W];
        norm_d.valid = full.valid;
        norm_d.sign  = full.sign;
        norm_d.kind  = full.kind;
        if (top_digit) begin
            norm_d.m  = full.prod[TOP -: MANT_W];
            norm_d.g0 = full.prod[G_W];
            norm_d.s0 = |full.prod[G_W-1:0];
            norm_d.e  = sexp_t'({2'b00, full.esum}) - sexp_t'(BIAS_WIDE);
        end else begin
            norm_d.m  = full.prod[TOP-DIGIT_W -: MANT_W];
            norm_d.g0 = full.prod[G_N];
            norm_d.s0 = |full.prod[G_N-1:0];
            norm_d.e  = sexp_t'({2'b00, full.esum}) - sexp_t'(BIAS_WIDE + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) norm <= '0;
        else     norm <= norm_d;
    end
endmodule

// File: rtl/hrfp_mul_round.sv
`timescale 1ns/1ps
module hrfp_mul_round
    import hrfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  norm_t norm,
    output rnd_t  rnd
);
    int                 lead_off;
    int                 ulp;
    logic               flush;
    logic [RND_W-1:0]   xw;
    logic [RND_W-1:0]   unit;
    logic [RND_W-1:0]   below;
    logic [RND_W-1:0]   sum;
    logic               guard_b;
    logic               sticky_b;
    logic               lsb_b;
    logic               bump;
    rnd_t               rnd_d;

    // ULP position inside the mantissa
    always_comb begin
        lead_off = 0;
        for (int i = 0; i < DIGIT_W; i++)
            if (norm.m[LEAD_LO + i]) lead_off = i;
        flush = 1'b0;
        ulp   = 0;
        if (norm.e > sexp_t'(EXP_EDGE) ||
            (norm.e == sexp_t'(EXP_EDGE) && (|norm.m[MANT_W-1 -: 2])))
            ulp = lead_off;
        else if (norm.e == sexp_t'(EXP_EDGE))
            ulp = SUB_ULP;
        else if (norm.e > sexp_t'(EXP_FLUSH))
            ulp = SUB_ULP + DIGIT_W * (EXP_EDGE - int'(norm.e));
        else
            flush = 1'b1;
    end

    // Round to nearest even at the chosen ULP, clear everything below it
    always_comb begin
        xw       = {1'b0, norm.m, norm.g0, norm.s0};
        unit     = RND_W'(1) << (ulp + 2);
        below    = unit - RND_W'(1);
        guard_b  = |(xw & (unit >> 1));
        sticky_b = |(xw & (below >> 1));
        lsb_b    = |(xw & unit);
        bump     = guard_b & (sticky_b | lsb_b);
        sum      = (xw & ~below) + (bump ? unit : '0);
        rnd_d.valid = norm.valid;
        rnd_d.sign  = norm.sign;
        rnd_d.kind  = norm.kind;
        rnd_d.e     = norm.e;
        rnd_d.flush = flush;
        rnd_d.mrnd  = (MANT_W+1)'(sum >> 2);
    end

    always_ff @(posedge clk) begin
        if (rst) rnd <= '0;
        else     rnd <= rnd_d;
    end
endmodule

// File: rtl/hrfp_mul_pack.sv
`timescale 1ns/1ps
module hrfp_mul_pack
    import hrfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rnd_t  rnd,
    output logic  out_valid,
    output word_t result
);
    logic  carry;
    mant_t mfin;
    sexp_t efin;
    word_t word_d;

    always_comb begin
        carry = rnd.mrnd[MANT_W];
        mfin  = carry ? mant_t'(rnd.mrnd >> DIGIT_W) : rnd.mrnd[MANT_W-1:0];
        efin  = rnd.e + (carry ? sexp_t'(1) : sexp_t'(0));
        if (rnd.kind != K_FIN)
            word_d = special_word(rnd.kind, rnd.sign);
        else if (rnd.flush || mfin == '0)
            word_d = special_word(K_ZERO, rnd.sign);
        else if (efin > sexp_t'(EXP_MAX))
            word_d = special_word(K_INF, rnd.sign);
        else
            word_d = {rnd.sign, 1'b0, exp_t'(efin), mfin};
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= rnd.valid;
        result <= word_d;
    end
endmodule

// File: rtl/hrfp_mul.sv
`timescale 1ns/1ps
module hrfp_mul
    import hrfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [35:0] op_a,
    input  logic [35:0] op_b,
    output logic        out_valid,
    output logic [35:0] result
);
    cap_t  cap;
    cap_t  cap_d;
    full_t full;
    norm_t norm;
    rnd_t  rnd;

    always_comb begin
        cap_d.valid = in_valid;
        cap_d.sign  = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        cap_d.kind  = product_kind(op_a, op_b);
        cap_d.ea    = op_a[MANT_W +: EXP_W];
        cap_d.eb    = op_b[MANT_W +: EXP_W];
        cap_d.ma    = op_a[MANT_W-1:0];
        cap_d.mb    = op_b[MANT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cap <= '0;
        else     cap <= cap_d;
    end

    hrfp_mul_product   u_prod (.clk(clk), .rst(rst), .cap(cap),   .full(full));
    hrfp_mul_normalize u_norm (.clk(clk), .rst(rst), .full(full), .norm(norm));
    hrfp_mul_round     u_rnd  (.clk(clk), .rst(rst), .norm(norm), .rnd(rnd));
    hrfp_mul_pack      u_pack (.clk(clk), .rst(rst), .rnd(rnd),
                               .out_valid(out_valid), .result(result));
endmodule

// File: rtl/hrfp_mul_chk.sv
`timescale 1ns/1ps
module hrfp_mul_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        a_sign,
    input logic        b_sign,
    input logic        out_valid,
    input logic [35:0] result
);
    logic [3:0] seen;
    always_ff @(posedge clk) begin
        if (rst)               seen <= '0;
        else if (seen != 4'hF) seen <= seen + 4'd1;
    end

    // R1
    latency_six_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 4'd7) |-> (out_valid == $past(in_valid, 6)));

    // R2
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 4'd7 && out_valid && !(result[34] && result[33]))
        |-> (result[35] == ($past(a_sign, 6) ^ $past(b_sign, 6))));

    // R8
    nan_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[34] && result[33]) |-> (!result[35] && result[32:0] == '0));

    // R7
    inf_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[34] && !result[33]) |-> (result[32:0] == '0));

    // R10
    trail_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !result[34] && result[33:27] > 7'd64 && result[26])
        |-> (result[2:0] == 3'b000));

    // R4
    sub_ulp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !result[34] && result[33:27] <= 7'd64) |-> (result[1:0] == 2'b00));

    // R5
    min_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !result[34] && result[26:0] != '0) |-> (result[33:27] >= 7'd58));

    // R5
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !result[34] && result[26:0] == '0) |-> (result[33:27] == '0));
endmodule

bind hrfp_mul hrfp_mul_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(op_a[35]), .b_sign(op_b[35]),
    .out_valid(out_valid), .result(result)
);

// File: tb/hrfp_mul_test.sv
`timescale 1ns/1ps
module hrfp_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [35:0] op_a = '0;
    logic [35:0] op_b = '0;
    logic        out_valid;
    logic [35:0] result;

    always #2.5 clk = ~clk;

    hrfp_mul uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
                  .out_valid(out_valid), .result(result));

    typedef struct {
        bit          v;
        logic [35:0] want;
        string       tag;
    } item_t;

    item_t pend[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic int msb64(longint unsigned v);
        for (int i = 63; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    // value = r * 2^ulpe, returned in canonical radix-16 form
    function automatic logic [35:0] encode(bit s, longint unsigned r, int ulpe);
        int q;
        int e;
        int sh;
        if (r == 0) return {s, 35'b0};
        q = msb64(r) + ulpe;
        if (q > 127) return {s, 2'b10, 33'b0};
        e  = (q + 384) / 4;
        sh = ulpe - (4 * e - 407);
        return {s, 1'b0, 7'(e), 27'(r << sh)};
    endfunction

    function automatic logic [35:0] from_ieee(logic [31:0] x);
        bit s = x[31];
        int e = int'(x[30:23]);
        longint unsigned f = longint'(x[22:0]);
        if (e == 255) return (f != 0) ? {s, 2'b11, 33'b0} : {s, 2'b10, 33'b0};
        if (e == 0 && f == 0) return {s, 35'b0};
        if (e == 0) return encode(s, f, -149);
        return encode(s, f | (64'd1 << 23), e - 150);
    endfunction

    function automatic logic [35:0] model(logic [35:0] a, logic [35:0] b);
        bit s  = a[35] ^ b[35];
        bit an = a[34] & a[33];
        bit ai = a[34] & !a[33];
        bit az = !a[34] && a[33:0] == 0;
        bit bn = b[34] & b[33];
        bit bi = b[34] & !b[33];
        bit bz = !b[34] && b[33:0] == 0;
        longint unsigned p, r, rem, half;
        int k, top, ulpe, sh;
        if (an || bn || (ai && bz) || (bi && az)) return {1'b0, 2'b11, 33'b0};
        if (ai || bi) return {s, 2'b10, 33'b0};
        if (az || bz) return {s, 35'b0};
        p    = longint'(a[26:0]) * longint'(b[26:0]);
        k    = 4 * (int'(a[33:27]) + int'(b[33:27])) - 814;
        top  = msb64(p) + k;
        ulpe = (top >= -126) ? top - 23 : -149;
        sh   = ulpe - k;
        if (sh > 55) r = 0;
        else begin
            r    = p >> sh;
            rem  = p & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            if (rem > half || (rem == half && r[0])) r = r + 1;
        end
        return encode(s, r, ulpe);
    endfunction

    function automatic string auto_tag(logic [35:0] w);
        if (w[34] && w[33]) return "R8";
        if (w[34]) return "R7";
        if (w[26:0] == 0) return "R5";
        if (w[33:27] <= 7'd64) return "R4";
        return "R3";
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic step(bit v, logic [35:0] a, logic [35:0] b, string tag);
        item_t it;
        @(negedge clk);
        if (pend.size() == 6) begin
            it = pend.pop_front();
            n_cmp++;
            if (out_valid !== it.v) begin
                n_bad++;
                $display("FAIL R1 valid: got %b expected %b", out_valid, it.v);
            end else if (it.v && result !== it.want) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h (a=%h b=%h)", it.tag, result, it.want, op_a, op_b);
            end
        end
        in_valid = v;
        op_a     = a;
        op_b     = b;
        it.v     = v;
        it.want  = model(a, b);
        it.tag   = (tag == "") ? auto_tag(it.want) : tag;
        pend.push_back(it);
    endtask

    task automatic mul32(logic [31:0] x, logic [31:0] y, string tag);
        step(1'b1, from_ieee(x), from_ieee(y), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin // R1 reset state
            n_bad++;
            $display("FAIL R1 reset: got %b expected 0", out_valid);
        end
        rst = 1'b0;
        // R3 plain products
        mul32(32'h3f800000, 32'h3f800000, "R3");
        mul32(32'h3f800000, 32'h40000000, "R3");
        mul32(32'h7f7fffff, 32'h3f800000, "R3");
        // R2 signs
        mul32(32'hc0000000, 32'h40400000, "R2");
        mul32(32'hc0000000, 32'hc0400000, "R2");
        // R10 sticky bits dropped
        mul32(32'h3f800001, 32'h3f800001, "R10");
        // R6 carry across a nibble boundary
        mul32(32'h417fffff, 32'h3f800001, "R6");
        mul32(32'h3fffffff, 32'h3f800001, "R6");
        // R4 subnormal emulation and boundary to the smallest normal
        mul32(32'h007fffff, 32'h3f800001, "R4");
        mul32(32'h00000001, 32'h3f400000, "R4");
        mul32(32'h00000001, 32'h3fc00000, "R4");
        mul32(32'h00000003, 32'h3f000000, "R4");
        // R5 flush and tie-to-even to zero
        mul32(32'h00000001, 32'h3f000000, "R5");
        mul32(32'h00000001, 32'h00000001, "R5");
        // R7 overflow
        mul32(32'h7f7fffff, 32'h7f7fffff, "R7");
        mul32(32'h7f7fffff, 32'h40000000, "R7");
        // R8 NaN cases
        mul32(32'h7fc00000, 32'h3f800000, "R8");
        mul32(32'h7f800000, 32'h00000000, "R8");
        mul32(32'h80000000, 32'hff800000, "R8");
        // R9 infinities and zeros
        mul32(32'h7f800000, 32'hc0000000, "R9");
        mul32(32'hff800000, 32'h7f800000, "R9");
        mul32(32'h00000000, 32'hc0400000, "R9");
        // R1 gaps in the valid stream
        step(1'b0, '0, '0, "R1");
        mul32(32'h40000000, 32'h40000000, "R1");
        step(1'b0, '0, '0, "R1");
        // random operands over the whole range
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(9) == 0) step(1'b0, '0, '0, "R1");
            else mul32($urandom, $urandom, "");
        end
        // random operands whose product lands near the subnormal band
        for (int i = 0; i < 2500; i++) begin
            int ea = $urandom_range(254);
            int t  = $urandom_range(34) - 153;
            int eb = t + 254 - ea;
            logic [31:0] x, y;
            if (eb < 0) eb = 0;
            if (eb > 254) eb = 254;
            x = {1'($urandom), 8'(ea), 23'($urandom)};
            y = {1'($urandom), 8'(eb), 23'($urandom)};
            mul32(x, y, "");
        end
        for (int i = 0; i < 8; i++) step(1'b0, '0, '0, "R1");
        done = 1;
        finish_run();
    end
endmodule